// File: doc/BRIEF.md
# Function Queue-Range Table Configurator

This block keeps, for every function of a queue manager, the contiguous range of hardware queues that function owns. Function 0 is the physical function. Functions 1 and up are virtual functions, which software gives consecutive ranges placed after the physical function's queues. Each function has two table entries. The submission-context entry holds a start queue, a queue count and a valid flag. The completion-context entry holds only a valid flag.

Software never writes the table directly. It fills a set of staged registers with a direction, a table kind, a function number and a 64-bit packed entry. It then clears the ready register and writes 1 to the go register. Ready stays low for a fixed number of cycles. At the end of that window the operation takes effect and ready returns high. A read operation copies the stored entry, in packed form, into the data registers. An operation that names an unknown function or an unknown kind leaves the table untouched and raises an error flag.

A separate lookup port maps a function number to its start queue, its queue count and both valid flags, combinationally from the stored table.

Top module: `queue_range_cfg`

## Requirements
- R1: After reset, ready reads 1, the error flag reads 0, and every function looks up as start 0, count 0, with both valid flags clear.
- R2: The registers sit at these indices: 0 go, 1 direction (bit 0: 0 = write, 1 = read), 2 kind (0 = submission, 1 = completion), 3 function, 4 data bits 31:0, 5 data bits 63:32, 6 ready (bit 0), 7 error (bit 0, read-only). While idle, direction, kind, function and both data words read back what was last written, and a write to index 6 sets ready to bit 0 of the written value.
- R3: A write of 1 to go while idle drives ready low on the next cycle. Ready returns to 1 exactly BUSY_CYCLES clock edges after the edge that captured the go write.
- R4: While an operation is in progress, writes to any register are ignored.
- R5: A submission write stores a packed entry with the start queue in bits 37:28, the valid flag in bit 44 and the queue count minus one in bits 54:45. The lookup then returns that start and the count (1 to 1024) with the submission valid flag set.
- R6: A completion write stores the valid flag from bit 28 of the packed entry. It changes neither that function's submission entry nor any other function's entries.
- R7: A read operation loads the addressed entry into the data registers, in the packing of R5 or R6 with all other bits zero, before ready returns high. It leaves the table unchanged.
- R8: An operation with a function number of NUM_FUNC or more, or a kind above 1, changes no table entry and sets the error flag, which is also driven on cfg_err_o. The next valid operation clears the flag.
- R9: A submission entry written with its valid flag clear, as done when software rolls back a function to base 0 and count 0, makes the lookup report start 0, count 0 and submission valid clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index for writes and reads |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the register at reg_addr_i (combinational) |
| lkp_func_i | input | clog2(NUM_FUNC) (3) | Function number to look up |
| lkp_start_o | output | 10 | First queue of the function |
| lkp_count_o | output | 11 | Number of queues of the function, 0 when not valid |
| lkp_sq_valid_o | output | 1 | Submission entry valid |
| lkp_cq_valid_o | output | 1 | Completion entry valid |
| cfg_err_o | output | 1 | Error flag of the last completed operation |

## Verification
The assertions assume that go is written only by the register port, one write per cycle, and that BUSY_CYCLES is at least 1. Under that assumption a commit falls only inside a busy window, and the staged registers move only on idle writes or on the commit of a read. The stimulus drives each register access for exactly one clock and changes inputs only on the falling edge. It always waits for ready before it stages a new operation, except where it deliberately writes during the busy window to show that such writes are dropped.

// File: rtl/qrt_pkg.sv
package qrt_pkg;
  typedef enum logic [2:0] {
    RI_GO   = 3'd0,
    RI_DIR  = 3'd1,
    RI_KIND = 3'd2,
    RI_FUNC = 3'd3,
    RI_DLO  = 3'd4,
    RI_DHI  = 3'd5,
    RI_RDY  = 3'd6,
    RI_ERR  = 3'd7
  } reg_idx_e;

  localparam int QF_W          = 10;  // start / count-1 field width
  localparam int SQ_START_LSB  = 28;
  localparam int SQ_VALID_BIT  = 44;
  localparam int SQ_CNT_LSB    = 45;
  localparam int CQ_VALID_BIT  = 28;
endpackage

// File: rtl/qrt_handshake.sv
module qrt_handshake #(
  parameter int BUSY_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic rdy_wr_i,
  input  logic rdy_val_i,
  output logic busy_o,
  output logic ready_o,
  output logic commit_o
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      ready_o <= 1'b1;
      cnt_q   <= '0;
    end else if (go_i) begin
      busy_o  <= 1'b1;
      ready_o <= 1'b0;
      cnt_q   <= CW'(BUSY_CYCLES - 1);
    end else if (busy_o) begin
      if (cnt_q == '0) begin
        busy_o  <= 1'b0;
        ready_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (rdy_wr_i) begin
      ready_o <= rdy_val_i;
    end
  end

  assign commit_o = busy_o && (cnt_q == '0);

  a_r3_ready_low_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ready_o);
  a_r3_go_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |=> (!ready_o && busy_o));
  a_r3_commit_raises_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (ready_o && !busy_o));
endmodule

// File: rtl/qrt_regs.sv
module qrt_regs
  import qrt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        busy_i,
  input  logic        ready_i,
  input  logic        commit_i,
  input  logic        op_bad_i,
  input  logic [63:0] rd_entry_i,
  output logic        go_o,
  output logic        rdy_wr_o,
  output logic        rdy_val_o,
  output logic        dir_o,
  output logic [31:0] kind_o,
  output logic [31:0] func_o,
  output logic [QF_W-1:0] wr_start_o,
  output logic [QF_W-1:0] wr_cntm1_o,
  output logic        wr_sqv_o,
  output logic        wr_cqv_o,
  output logic        err_o
);
  logic [31:0] dlo_q, dhi_q;
  logic [63:0] data;
  logic        idle_wr;

  assign idle_wr   = reg_we_i && !busy_i;
  assign go_o      = idle_wr && (reg_addr_i == RI_GO) && reg_wdata_i[0];
  assign rdy_wr_o  = idle_wr && (reg_addr_i == RI_RDY);
  assign rdy_val_o = reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= 1'b0;
      kind_o <= '0;
      func_o <= '0;
      dlo_q  <= '0;
      dhi_q  <= '0;
      err_o  <= 1'b0;
    end else begin
      if (idle_wr) begin
        unique case (reg_addr_i)
          RI_DIR:  dir_o  <= reg_wdata_i[0];
          RI_KIND: kind_o <= reg_wdata_i;
          RI_FUNC: func_o <= reg_wdata_i;
          RI_DLO:  dlo_q  <= reg_wdata_i;
          RI_DHI:  dhi_q  <= reg_wdata_i;
          default: ;
        endcase
      end
      if (commit_i) begin
        err_o <= op_bad_i;
        if (!op_bad_i && dir_o) begin
          dlo_q <= rd_entry_i[31:0];
          dhi_q <= rd_entry_i[63:32];
        end
      end
    end
  end

  assign data       = {dhi_q, dlo_q};
  assign wr_start_o = data[SQ_START_LSB +: QF_W];
  assign wr_cntm1_o = data[SQ_CNT_LSB +: QF_W];
  assign wr_sqv_o   = data[SQ_VALID_BIT];
  assign wr_cqv_o   = data[CQ_VALID_BIT];

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RI_GO:   reg_rdata_o[0] = busy_i;
      RI_DIR:  reg_rdata_o[0] = dir_o;
      RI_KIND: reg_rdata_o    = kind_o;
      RI_FUNC: reg_rdata_o    = func_o;
      RI_DLO:  reg_rdata_o    = dlo_q;
      RI_DHI:  reg_rdata_o    = dhi_q;
      RI_RDY:  reg_rdata_o[0] = ready_i;
      RI_ERR:  reg_rdata_o[0] = err_o;
      default: reg_rdata_o    = '0;
    endcase
  end

  a_r4_ctrl_frozen_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(dir_o) && $stable(kind_o) && $stable(func_o)));
  a_r4_data_frozen_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !commit_i) |=> ($stable(dlo_q) && $stable(dhi_q)));
  a_r8_err_on_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && op_bad_i) |=> err_o);
  a_r8_err_clear_good: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !op_bad_i) |=> !err_o);
endmodule

// File: rtl/qrt_table.sv
module qrt_table
  import qrt_pkg::*;
#(
  parameter int NUM_FUNC = 8,
  localparam int FW = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            commit_i,
  input  logic            dir_i,
  input  logic [31:0]     kind_i,
  input  logic [31:0]     func_i,
  input  logic [QF_W-1:0] wr_start_i,
  input  logic [QF_W-1:0] wr_cntm1_i,
  input  logic            wr_sqv_i,
  input  logic            wr_cqv_i,
  output logic            op_bad_o,
  output logic [63:0]     rd_entry_o,
  input  logic [FW-1:0]   lkp_func_i,
  output logic [QF_W-1:0] lkp_start_o,
  output logic [QF_W:0]   lkp_count_o,
  output logic            lkp_sq_valid_o,
  output logic            lkp_cq_valid_o
);
  logic [NUM_FUNC-1:0][QF_W-1:0] sq_start_q, sq_cntm1_q;
  logic [NUM_FUNC-1:0]           sq_vld_q, cq_vld_q;
  logic [FW-1:0]                 fidx;
  logic                          wr_ok;

  assign op_bad_o = (func_i >= 32'(NUM_FUNC)) || (kind_i > 32'd1);
  assign fidx     = func_i[FW-1:0];
  assign wr_ok    = commit_i && !op_bad_o && !dir_i;

  for (genvar g = 0; g < NUM_FUNC; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sq_start_q[g] <= '0;
        sq_cntm1_q[g] <= '0;
        sq_vld_q[g]   <= 1'b0;
        cq_vld_q[g]   <= 1'b0;
      end else if (wr_ok && (fidx == FW'(g))) begin
        if (kind_i[0]) begin
          cq_vld_q[g] <= wr_cqv_i;
        end else begin
          sq_start_q[g] <= wr_start_i;
          sq_cntm1_q[g] <= wr_cntm1_i;
          sq_vld_q[g]   <= wr_sqv_i;
        end
      end
    end
  end

  always_comb begin
    rd_entry_o = '0;
    if (!op_bad_o) begin
      if (kind_i[0]) begin
        rd_entry_o[CQ_VALID_BIT] = cq_vld_q[fidx];
      end else begin
        rd_entry_o[SQ_START_LSB +: QF_W] = sq_start_q[fidx];
        rd_entry_o[SQ_CNT_LSB +: QF_W]   = sq_cntm1_q[fidx];
        rd_entry_o[SQ_VALID_BIT]         = sq_vld_q[fidx];
      end
    end
  end

  always_comb begin
    lkp_start_o    = '0;
    lkp_count_o    = '0;
    lkp_sq_valid_o = 1'b0;
    lkp_cq_valid_o = 1'b0;
    if (32'(lkp_func_i) < NUM_FUNC) begin
      lkp_cq_valid_o = cq_vld_q[lkp_func_i];
      if (sq_vld_q[lkp_func_i]) begin
        lkp_sq_valid_o = 1'b1;
        lkp_start_o    = sq_start_q[lkp_func_i];
        lkp_count_o    = {1'b0, sq_cntm1_q[lkp_func_i]} + 1'b1;
      end
    end
  end

  a_r8_bad_keeps_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && op_bad_o) |=> ($stable(sq_start_q) && $stable(sq_cntm1_q)
                                && $stable(sq_vld_q) && $stable(cq_vld_q)));
  a_r7_read_keeps_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && dir_i) |=> ($stable(sq_start_q) && $stable(sq_cntm1_q)
                             && $stable(sq_vld_q) && $stable(cq_vld_q)));
  a_r6_cq_keeps_sq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && kind_i[0]) |=> ($stable(sq_start_q) && $stable(sq_cntm1_q)
                                 && $stable(sq_vld_q)));
  a_r4_table_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(sq_vld_q) && $stable(cq_vld_q)));
endmodule

// File: rtl/queue_range_cfg.sv
module queue_range_cfg
  import qrt_pkg::*;
#(
  parameter int NUM_FUNC    = 8,
  parameter int BUSY_CYCLES = 4,
  localparam int FW = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [2:0]      reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  input  logic [FW-1:0]   lkp_func_i,
  output logic [QF_W-1:0] lkp_start_o,
  output logic [QF_W:0]   lkp_count_o,
  output logic            lkp_sq_valid_o,
  output logic            lkp_cq_valid_o,
  output logic            cfg_err_o
);
  logic            go, rdy_wr, rdy_val, busy, ready, commit, op_bad, dir;
  logic [31:0]     kind, func;
  logic [63:0]     rd_entry;
  logic [QF_W-1:0] wr_start, wr_cntm1;
  logic            wr_sqv, wr_cqv;

  qrt_handshake #(.BUSY_CYCLES(BUSY_CYCLES)) u_hs (
    .clk_i, .rst_ni,
    .go_i(go), .rdy_wr_i(rdy_wr), .rdy_val_i(rdy_val),
    .busy_o(busy), .ready_o(ready), .commit_o(commit)
  );

  qrt_regs u_regs (
    .clk_i, .rst_ni,
    .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .ready_i(ready), .commit_i(commit), .op_bad_i(op_bad),
    .rd_entry_i(rd_entry),
    .go_o(go), .rdy_wr_o(rdy_wr), .rdy_val_o(rdy_val),
    .dir_o(dir), .kind_o(kind), .func_o(func),
    .wr_start_o(wr_start), .wr_cntm1_o(wr_cntm1),
    .wr_sqv_o(wr_sqv), .wr_cqv_o(wr_cqv),
    .err_o(cfg_err_o)
  );

  qrt_table #(.NUM_FUNC(NUM_FUNC)) u_tbl (
    .clk_i, .rst_ni,
    .commit_i(commit), .dir_i(dir), .kind_i(kind), .func_i(func),
    .wr_start_i(wr_start), .wr_cntm1_i(wr_cntm1),
    .wr_sqv_i(wr_sqv), .wr_cqv_i(wr_cqv),
    .op_bad_o(op_bad), .rd_entry_o(rd_entry),
    .lkp_func_i, .lkp_start_o, .lkp_count_o, .lkp_sq_valid_o, .lkp_cq_valid_o
  );
endmodule

// File: tb/queue_range_cfg_tb.sv
`timescale 1ns/1ps
module queue_range_cfg_tb;
  localparam int NF = 8;
  localparam int BC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  lfunc = '0;
  logic [9:0]  lstart;
  logic [10:0] lcount;
  logic        lsqv, lcqv, err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  queue_range_cfg #(.NUM_FUNC(NF), .BUSY_CYCLES(BC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .lkp_func_i(lfunc), .lkp_start_o(lstart), .lkp_count_o(lcount),
    .lkp_sq_valid_o(lsqv), .lkp_cq_valid_o(lcqv), .cfg_err_o(err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [63:0] mk_sq(input int start, input int cnt, input bit v);
    logic [63:0] e = '0;
    e[37:28] = start[9:0];
    e[44]    = v;
    e[54:45] = 10'(cnt - 1);
    return e;
  endfunction

  task automatic wait_ready(input string req);
    logic [31:0] d;
    for (int i = 0; i < 50; i++) begin
      reg_rd(3'd6, d);
      if (d[0]) return;
      @(negedge clk);
    end
    chk(1'b0, req, 0, 1);
  endtask

  task automatic run_op(input bit rd, input int kind, input int func, input logic [63:0] e);
    wait_ready("ready before op");
    reg_wr(3'd1, {31'd0, rd});
    reg_wr(3'd2, kind);
    reg_wr(3'd3, func);
    reg_wr(3'd4, e[31:0]);
    reg_wr(3'd5, e[63:32]);
    reg_wr(3'd6, 32'd0);
    reg_wr(3'd0, 32'd1);
    wait_ready("ready after op");
  endtask

  task automatic look(input int f, input int st, input int cnt, input bit sqv, input bit cqv, input string req);
    lfunc = f[2:0];
    #1;
    chk(lstart == st[9:0], req, lstart, st);
    chk(lcount == cnt[10:0], req, lcount, cnt);
    chk(lsqv == sqv, req, lsqv, sqv);
    chk(lcqv == cqv, req, lcqv, cqv);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    reg_rd(3'd6, d); chk(d == 1, "R1 ready", d, 1);
    reg_rd(3'd7, d); chk(d == 0, "R1 err", d, 0);
    chk(err == 0, "R1 err pin", err, 0);
    for (int f = 0; f < NF; f++) look(f, 0, 0, 0, 0, "R1 lookup");
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    reg_wr(3'd1, 32'd1);         reg_rd(3'd1, d); chk(d == 1, "R2 dir", d, 1);
    reg_wr(3'd2, 32'd3);         reg_rd(3'd2, d); chk(d == 3, "R2 kind", d, 3);
    reg_wr(3'd3, 32'd5);         reg_rd(3'd3, d); chk(d == 5, "R2 func", d, 5);
    reg_wr(3'd4, 32'h1234_5678); reg_rd(3'd4, d); chk(d == 32'h1234_5678, "R2 dlo", d, 32'h1234_5678);
    reg_wr(3'd5, 32'h9abc_def0); reg_rd(3'd5, d); chk(d == 32'h9abc_def0, "R2 dhi", d, 32'h9abc_def0);
    reg_wr(3'd6, 32'd0);         reg_rd(3'd6, d); chk(d == 0, "R2 ready clear", d, 0);
    reg_wr(3'd6, 32'd1);         reg_rd(3'd6, d); chk(d == 1, "R2 ready set", d, 1);
    reg_wr(3'd7, 32'd1);         reg_rd(3'd7, d); chk(d == 0, "R2 err read-only", d, 0);
  endtask

  task automatic t_timing;
    logic [31:0] d;
    logic [63:0] e = mk_sq(0, 16, 1);
    // stage a PF write, then time the handshake
    reg_wr(3'd1, 0); reg_wr(3'd2, 0); reg_wr(3'd3, 0);
    reg_wr(3'd4, e[31:0]); reg_wr(3'd5, e[63:32]); reg_wr(3'd6, 0);
    reg_wr(3'd0, 1);
    reg_rd(3'd6, d); chk(d == 0, "R3 ready low after go", d, 0);
    repeat (BC - 1) @(negedge clk);
    reg_rd(3'd6, d); chk(d == 0, "R3 ready low before window end", d, 0);
    @(negedge clk);
    reg_rd(3'd6, d); chk(d == 1, "R3 ready high at window end", d, 1);
    look(0, 0, 16, 1, 0, "R5 pf entry");
    // writes inside the busy window are dropped
    reg_wr(3'd1, 0); reg_wr(3'd2, 0); reg_wr(3'd3, 1);
    e = mk_sq(16, 8, 1);
    reg_wr(3'd4, e[31:0]); reg_wr(3'd5, e[63:32]); reg_wr(3'd6, 0);
    reg_wr(3'd0, 1);
    reg_wr(3'd6, 1);
    reg_rd(3'd6, d); chk(d == 0, "R4 ready write ignored", d, 0);
    reg_wr(3'd4, 32'hdead_beef);
    wait_ready("R4 wait");
    reg_rd(3'd4, d); chk(d == e[31:0], "R4 dlo write ignored", d, e[31:0]);
    look(1, 16, 8, 1, 0, "R5 vf1 entry");
  endtask

  task automatic t_sq_write;
    run_op(0, 0, 2, mk_sq(24, 8, 1));
    look(2, 24, 8, 1, 0, "R5 vf2 consecutive");
    run_op(0, 0, 7, mk_sq(1000, 1024, 1));
    look(7, 1000, 1024, 1, 0, "R5 max count");
    run_op(0, 0, 6, mk_sq(32, 1, 1));
    look(6, 32, 1, 1, 0, "R5 count one");
    look(1, 16, 8, 1, 0, "R5 vf1 untouched");
  endtask

  task automatic t_cq_write;
    run_op(0, 1, 1, 64'h1000_0000);
    look(1, 16, 8, 1, 1, "R6 cq valid sq kept");
    look(2, 24, 8, 1, 0, "R6 other function kept");
  endtask

  task automatic t_readback;
    logic [31:0] lo, hi;
    logic [63:0] e = mk_sq(16, 8, 1);
    run_op(1, 0, 1, 64'h0);
    reg_rd(3'd4, lo); reg_rd(3'd5, hi);
    chk({hi, lo} == e, "R7 sq readback", {hi, lo}, e);
    run_op(1, 1, 1, 64'hffff_ffff_ffff_ffff);
    reg_rd(3'd4, lo); reg_rd(3'd5, hi);
    chk({hi, lo} == 64'h1000_0000, "R7 cq readback", {hi, lo}, 64'h1000_0000);
    run_op(1, 0, 3, 64'hffff_ffff_ffff_ffff);
    reg_rd(3'd4, lo); reg_rd(3'd5, hi);
    chk({hi, lo} == 64'h0, "R7 empty readback", {hi, lo}, 0);
    look(1, 16, 8, 1, 1, "R7 table unchanged");
  endtask

  task automatic t_bad;
    logic [31:0] d;
    run_op(0, 0, 9, mk_sq(5, 5, 1));
    reg_rd(3'd7, d); chk(d == 1, "R8 err bad func", d, 1);
    chk(err == 1, "R8 err pin", err, 1);
    for (int f = 0; f < NF; f++) begin
      lfunc = f[2:0]; #1;
      chk(!(lsqv && lstart == 5), "R8 no entry written", lstart, 0);
    end
    run_op(0, 2, 2, mk_sq(99, 3, 1));
    reg_rd(3'd7, d); chk(d == 1, "R8 err bad kind", d, 1);
    look(2, 24, 8, 1, 0, "R8 vf2 unchanged");
    run_op(0, 1, 2, 64'h1000_0000);
    reg_rd(3'd7, d); chk(d == 0, "R8 err cleared", d, 0);
  endtask

  task automatic t_rollback;
    run_op(0, 0, 1, mk_sq(0, 0, 0));
    look(1, 0, 0, 0, 1, "R9 rollback");
    look(2, 24, 8, 1, 1, "R9 neighbour kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_timing();
    t_sq_write();
    t_cq_write();
    t_readback();
    t_bad();
    t_rollback();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule